// File: doc/BRIEF.md
# Flash Driver Fault Status and Attention Logic

This block holds the eight-bit fault and status word of a camera flash LED controller. Five fault indications (LED fault, NTC warning comparator, NTC hot comparator, die over-temperature and output-voltage-not-good) arrive as asynchronous digital levels. Each one passes through a two-flop synchroniser, and a rising edge of its synchronised level sets a sticky bit. A sticky bit stays set until the host reads the status word over the serial bus. The flash-running flag is shown in real time and is never latched.

From the sticky bits the block derives three outputs. The active-low attention line goes low while any fault is held. A force-ready request asks the mode controller to drop to ready mode; the NTC warning bit alone does not raise it, because that bit is only a warning. A lock output tells the register file to freeze the trigger enable, the torch enable and the auxiliary LED register until the faults are cleared. When the flash timer expires, the attention line also gives a low pulse of fixed length, set in clock cycles from the clock frequency and the pulse width in microseconds. This pulse does not depend on the faults.

A read strobe clears each sticky bit whose condition is gone. A bit whose synchronised condition is still present at the read stays set.

Top module: `fault_status_latch`

## Requirements
- R1: After reset, every latched bit is 0, attn_n_o is 1, force_ready_o is 0 and lock_o is 0.
- R2: status_o has this layout: bit 7 = 0, bit 6 = flash running, bit 5 = LED fault, bit 4 = NTC warning, bit 3 = NTC hot, bit 2 = over-temperature, bit 1 = 0, bit 0 = output voltage not good.
- R3: status_o bit 6 equals flash_active_i in the same cycle. It is not latched and has no effect on attn_n_o, force_ready_o or lock_o.
- R4: A rising fault input appears in status_o after the third rising clock edge following the change (two synchroniser stages and one latch stage). The bit stays set after the input falls.
- R5: A cycle with status_rd_i high clears every latched bit whose synchronised input is low. A bit whose synchronised input is still high stays set.
- R6: attn_n_o is low in every cycle in which any latched fault bit is set.
- R7: force_ready_o is high when the LED fault, NTC hot, over-temperature or voltage-not-good bit is latched. A latched NTC warning alone leaves it low.
- R8: lock_o is high exactly while any fault bit is latched.
- R9: A flash_expired_i strobe drives attn_n_o low for PULSE_CYC = (CLK_HZ/1e6)*PULSE_US consecutive cycles, starting after the edge that samples the strobe. This happens with or without latched faults.
- R10: A new expiry strobe during a pulse restarts the full PULSE_CYC window. A status read does not shorten a running pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| led_fault_i | input | 1 | LED open/short fault level, asynchronous |
| ntc_warn_i | input | 1 | NTC warning comparator output, asynchronous |
| ntc_hot_i | input | 1 | NTC hot comparator output, asynchronous |
| overtemp_i | input | 1 | Die over-temperature level, asynchronous |
| vout_bad_i | input | 1 | Output voltage not good level, asynchronous |
| flash_active_i | input | 1 | Flash running flag, synchronous |
| flash_expired_i | input | 1 | One-cycle strobe at flash timer expiry |
| status_rd_i | input | 1 | One-cycle strobe when the status word is read |
| status_o | output | 8 | Status word |
| attn_n_o | output | 1 | Active-low attention line |
| force_ready_o | output | 1 | Request to drop to ready mode |
| lock_o | output | 1 | Freeze trigger enable, torch enable and auxiliary register |

## Verification
The bench attacks the read that lands while a condition is still active. A design that cleared unconditionally would lose a fault that is still present, and one that ignored the level would never clear. The NTC warning is run on its own to catch a force-ready mask that treats it as severe. The flash-running flag is checked to confirm it raises neither attention nor lock. The timeout pulse is measured to the exact cycle, both alone and when retriggered, to catch off-by-one counters and a pulse that a retrigger or a status read fails to extend or cuts short.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
    localparam int NFLT    = 5;
    // fault vector indices
    localparam int FI_VOUT = 0;
    localparam int FI_OT   = 1;
    localparam int FI_HOT  = 2;
    localparam int FI_WARN = 3;
    localparam int FI_LED  = 4;
    // status word positions (software decodes these)
    localparam int SB_VOUT = 0;
    localparam int SB_OT   = 2;
    localparam int SB_HOT  = 3;
    localparam int SB_WARN = 4;
    localparam int SB_LED  = 5;
    localparam int SB_RUN  = 6;
    localparam int STAT_W  = 8;
    // faults that demand a drop to ready mode
    localparam logic [NFLT-1:0] FORCE_MASK =
        (NFLT'(1) << FI_VOUT) | (NFLT'(1) << FI_OT) |
        (NFLT'(1) << FI_HOT)  | (NFLT'(1) << FI_LED);
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.s3;

    // R4: an edge report lasts a single cycle per bit
    assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/fault_latch_bank.sv
module fault_latch_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] rise_i,
    input  logic         rd_i,
    output logic [W-1:0] lat_o
);
    typedef struct packed {
        logic [W-1:0] lat;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) st_d.lat = lvl_i | rise_i;
        else      st_d.lat = st_q.lat | rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_o = st_q.lat;

    // R4: without a read, set bits never drop
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((lat_o & $past(lat_o)) == $past(lat_o)));
    // R5: after a read, only still-present conditions remain
    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((lat_o & ~$past(lvl_i)) == '0));
endmodule

// File: rtl/attn_pulse_gen.sv
module attn_pulse_gen #(
    parameter int PULSE_CYC = 2200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    output logic pulse_o
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pg_t;

    pg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (expire_i)           st_d.cnt = CW'(PULSE_CYC);
        else if (st_q.cnt != 0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = (st_q.cnt != '0);

    // R9: counter never runs past the window length
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(PULSE_CYC));
    // R10: each strobe reloads the full window
    assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> (st_q.cnt == CW'(PULSE_CYC)));
endmodule

// File: rtl/fault_status_latch.sv
module fault_status_latch
    import flash_stat_pkg::*;
#(
    parameter int CLK_HZ   = 200_000_000,
    parameter int PULSE_US = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        led_fault_i,
    input  logic        ntc_warn_i,
    input  logic        ntc_hot_i,
    input  logic        overtemp_i,
    input  logic        vout_bad_i,
    input  logic        flash_active_i,
    input  logic        flash_expired_i,
    input  logic        status_rd_i,
    output logic [7:0]  status_o,
    output logic        attn_n_o,
    output logic        force_ready_o,
    output logic        lock_o
);
    localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;

    logic [NFLT-1:0] raw, lvl, rise, lat;
    logic            pulse;

    always_comb begin
        raw          = '0;
        raw[FI_VOUT] = vout_bad_i;
        raw[FI_OT]   = overtemp_i;
        raw[FI_HOT]  = ntc_hot_i;
        raw[FI_WARN] = ntc_warn_i;
        raw[FI_LED]  = led_fault_i;
    end

    fault_sync #(.W(NFLT)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .lvl_o(lvl), .rise_o(rise)
    );

    fault_latch_bank #(.W(NFLT)) u_bank (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_i(rise),
        .rd_i(status_rd_i), .lat_o(lat)
    );

    attn_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .expire_i(flash_expired_i), .pulse_o(pulse)
    );

    always_comb begin
        status_o          = '0;
        status_o[SB_VOUT] = lat[FI_VOUT];
        status_o[SB_OT]   = lat[FI_OT];
        status_o[SB_HOT]  = lat[FI_HOT];
        status_o[SB_WARN] = lat[FI_WARN];
        status_o[SB_LED]  = lat[FI_LED];
        status_o[SB_RUN]  = flash_active_i;
    end

    assign lock_o        = |lat;
    assign force_ready_o = |(lat & FORCE_MASK);
    assign attn_n_o      = ~(lock_o | pulse);

    // R7: a ready request always comes with the lock
    assert_force_implies_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        force_ready_o |-> lock_o);
    // R6: held faults keep attention asserted
    assert_lock_pulls_attn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> !attn_n_o);
    // R9: expiry strobe drives attention low on the next cycle
    assert_expiry_attn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flash_expired_i |=> !attn_n_o);
endmodule

// File: tb/fault_status_latch_test.sv
`timescale 1ns/1ps
module fault_status_latch_test;
    localparam int CLK_HZ = 2_000_000;
    localparam int PUS    = 3;
    localparam int PCYC   = (CLK_HZ / 1_000_000) * PUS;

    logic clk = 0, rst_n = 0;
    logic led_f = 0, warn = 0, hot = 0, ot = 0, vout = 0;
    logic frun = 0, fexp = 0, rd = 0;
    logic [7:0] status;
    logic attn_n, force_rdy, lock;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fault_status_latch #(.CLK_HZ(CLK_HZ), .PULSE_US(PUS)) uut (
        .clk(clk), .rst_n(rst_n), .led_fault_i(led_f), .ntc_warn_i(warn),
        .ntc_hot_i(hot), .overtemp_i(ot), .vout_bad_i(vout),
        .flash_active_i(frun), .flash_expired_i(fexp), .status_rd_i(status_rd_w),
        .status_o(status), .attn_n_o(attn_n), .force_ready_o(force_rdy), .lock_o(lock)
    );
    logic status_rd_w;
    assign status_rd_w = rd;

    // {faults[led,warn,hot,ot,vout], expected status, expected force}
    localparam logic [13:0] VEC [7] = '{
        {5'b10000, 8'b0010_0000, 1'b1},
        {5'b01000, 8'b0001_0000, 1'b0},
        {5'b00100, 8'b0000_1000, 1'b1},
        {5'b00010, 8'b0000_0100, 1'b1},
        {5'b00001, 8'b0000_0001, 1'b1},
        {5'b01001, 8'b0001_0001, 1'b1},
        {5'b11111, 8'b0011_1101, 1'b1}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_faults(input logic [4:0] f);
        {led_f, warn, hot, ot, vout} = f;
    endtask

    task automatic do_read();
        rd = 1; step(1); rd = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1 reset state
        check("R1 status", status, 0);
        check("R1 attn_n", attn_n, 1);
        check("R1 force", force_rdy, 0);
        check("R1 lock", lock, 0);
        rst_n = 1;
        step(2);
        check("R1 idle after reset", {status, attn_n, force_rdy, lock}, {8'h00, 3'b100});

        // table walk: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < 7; i++) begin
            set_faults(VEC[i][13:9]);
            step(2);
            check("R4 not before third edge", status, 0);
            step(1);
            check("R2 R4 status layout", status, VEC[i][8:1]);
            check("R7 force ready", force_rdy, VEC[i][0]);
            check("R8 lock", lock, 1);
            check("R6 attn low", attn_n, 0);
            set_faults(5'b0);
            step(3);
            check("R4 sticky after drop", status, VEC[i][8:1]);
            do_read();
            check("R5 cleared", {status, lock, force_rdy, attn_n}, {8'h00, 3'b001});
        end

        // R3 flash running flag
        frun = 1; #1;
        check("R3 f_run visible", status, 8'h40);
        check("R3 no attn", attn_n, 1);
        check("R3 no lock", {lock, force_rdy}, 0);
        frun = 0; #1;
        check("R3 f_run not latched", status, 8'h00);

        // R5 read while condition present keeps bit
        hot = 1; step(3);
        do_read();
        check("R5 still present stays", status, 8'h08);
        hot = 0; step(3);
        check("R5 held until read", status, 8'h08);
        do_read();
        check("R5 clears once gone", status, 8'h00);

        // R9 timeout pulse length
        fexp = 1; step(1); fexp = 0;
        check("R9 pulse start", attn_n, 0);
        check("R9 pulse no lock", lock, 0);
        step(PCYC - 1);
        check("R9 pulse last cycle", attn_n, 0);
        step(1);
        check("R9 pulse ended", attn_n, 1);

        // R10 retrigger and read during pulse
        fexp = 1; step(1); fexp = 0;
        step(2);
        fexp = 1; step(1); fexp = 0;
        do_read();
        step(PCYC - 2);
        check("R10 retrigger extends", attn_n, 0);
        step(1);
        check("R10 retrigger ends", attn_n, 1);

        // R9 pulse independent of fault: fault latched, clear during pulse
        ot = 1; step(3); ot = 0; step(2);
        fexp = 1; step(1); fexp = 0;
        do_read();
        check("R9 pulse survives fault clear", {attn_n, lock}, 2'b00);
        step(PCYC - 2);
        check("R9 pulse tail", attn_n, 0);
        step(1);
        check("R9 pulse after fault done", attn_n, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule